// File: doc/BRIEF.md
# Interrupt Active Priority Tracker

This block follows the preemption levels that are currently in service on one processor interface of an interrupt controller and turns them into a running priority. Each accepted interrupt sends an activate command carrying its 8-bit group priority and group membership. The block reduces that priority to a preemption level and marks the level in a bitmap of active-priority registers. Each end-of-interrupt sends a priority-drop command naming a group. The block then releases the most urgent marked level of that group and rebuilds the running priority from whatever is still marked.

A parameter selects one of two variants. The physical variant keeps two banks of 32-bit registers, one per group, with a minimum binary point of 0 (128 levels in four registers per bank). The virtual variant keeps one 32-bit register that ignores groups, with a minimum binary point of 2 (32 levels).

Commands are single-cycle pulses. They are always accepted, so there is no back-pressure, and they never coincide. The running priority changes on the clock edge after a command and otherwise holds.

Top module: `prio_tracker`

## Requirements
- R1: After reset every active-priority bit is clear and run_prio reads 0x100, the idle value.
- R2: act_valid and drop_valid are single-cycle pulses that never both assert. One cycle after an activate, run_prio equals the activated priority zero-extended to 9 bits. With no command, run_prio holds.
- R3: An activate marks level = priority >> (min binary point + 1). After a drop, run_prio = (lowest marked level) << (min binary point + 1). In the physical variant the search covers both banks combined, and a level's index is register number × 32 + bit position.
- R4: In the physical variant the level goes to the group-1 bank only when grp_en and act_grp1 are both 1. Otherwise it goes to the group-0 bank. drop_grp1 = 1 selects the group-1 bank for a drop.
- R5: A drop clears only the lowest marked level of the selected bank. The scan runs across registers in ascending order, so a level in register 1 is cleared only once register 0 is empty.
- R6: A drop on an empty bank changes no bit. run_prio is still rebuilt from the other bank.
- R7: When a drop leaves no marked level anywhere, run_prio becomes 0x100. A further drop keeps it at 0x100.
- R8: The virtual variant uses one 32-bit register and a minimum binary point of 2, and ignores act_grp1, grp_en and drop_grp1. Its drop clears the lowest set bit only if the register is nonzero. A parameter set that needs more than one register is rejected at elaboration.
- R9: Activating the same level twice leaves a single mark, and one drop releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activate command pulse |
| act_prio | input | 8 | Group priority of the activated interrupt |
| act_grp1 | input | 1 | Activated interrupt belongs to group 1 |
| grp_en | input | 1 | Interrupt groups are enabled |
| drop_valid | input | 1 | Priority-drop command pulse |
| drop_grp1 | input | 1 | Drop targets the group-1 bank |
| run_prio | output | 9 | Running priority, 0x100 when idle |

## Verification
The bench goes after the register boundary between levels 31 and 32. A design that cleared bits in every nonzero register, or scanned registers from the top, would release the wrong level there. It drops on an empty bank while the other bank still holds levels; a design that skipped the rebuild would keep a stale activated priority, and one that cleared the other bank would drop to idle. It activates group-1 interrupts with groups disabled, where misrouting shows up as a group-1 drop removing the level. It also activates odd priorities, where a drop must report the level grid value rather than the original priority.

// File: rtl/prio_tracker_pkg.sv
package prio_tracker_pkg;

  localparam int APR_W   = 32;
  localparam int APR_BIT_W = $clog2(APR_W);

  // number of APR_W-wide registers needed for the levels of one bank
  function automatic int reg_count(input int prio_w, input int min_bp);
    return ((1 << (prio_w - min_bp - 1)) + APR_W - 1) / APR_W;
  endfunction

endpackage

// File: rtl/prio_level_map.sv
module prio_level_map
  import prio_tracker_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int MIN_BP = 0,
  parameter int RIDX_W = 2
) (
  input  logic [PRIO_W-1:0]    prio,
  output logic [RIDX_W-1:0]    reg_idx,
  output logic [APR_BIT_W-1:0] bit_idx
);

  logic [31:0] level;

  always_comb begin
    level   = 32'(prio) >> (MIN_BP + 1);
    reg_idx = RIDX_W'(level >> APR_BIT_W);
    bit_idx = level[APR_BIT_W-1:0];
  end

endmodule

// File: rtl/apr_bank.sv
module apr_bank
  import prio_tracker_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    set_en,
  input  logic [RIDX_W-1:0]       set_reg,
  input  logic [APR_BIT_W-1:0]    set_bit,
  input  logic                    clr_en,
  output logic [NREG*APR_W-1:0]   bank_next
);

  // below_empty[r]: every register with a lower index is zero
  logic [NREG-1:0] below_empty;
  assign below_empty[0] = 1'b1;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [APR_W-1:0] q_r;
    logic [APR_W-1:0] nxt_r;

    if (r < NREG - 1) begin : g_chain
      assign below_empty[r+1] = below_empty[r] && (q_r == '0);
    end

    always_comb begin
      nxt_r = q_r;
      if (set_en && set_reg == RIDX_W'(r)) begin
        nxt_r[set_bit] = 1'b1;
      end
      if (clr_en && below_empty[r] && q_r != '0) begin
        nxt_r = q_r & (q_r - APR_W'(1));
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= nxt_r;
    end

    assign bank_next[r*APR_W +: APR_W] = nxt_r;
  end

endmodule

// File: rtl/lowest_set_idx.sv
module lowest_set_idx #(
  parameter int W     = 128,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             found
);

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/prio_tracker.sv
module prio_tracker
  import prio_tracker_pkg::*;
#(
  parameter int PRIO_W      = 8,
  parameter int MIN_BP_PHYS = 0,
  parameter int MIN_BP_VIRT = 2,
  parameter bit VIRT        = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  input  logic [PRIO_W-1:0] act_prio,
  input  logic              act_grp1,
  input  logic              grp_en,
  input  logic              drop_valid,
  input  logic              drop_grp1,
  output logic [PRIO_W:0]   run_prio
);

  localparam int MIN_BP = VIRT ? MIN_BP_VIRT : MIN_BP_PHYS;
  localparam int NREG   = reg_count(PRIO_W, MIN_BP);
  localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int FLAT_W = NREG * APR_W;
  localparam int IDX_W  = $clog2(FLAT_W);
  localparam int NBANK  = VIRT ? 1 : 2;
  localparam int RUN_W  = PRIO_W + 1;
  localparam logic [RUN_W-1:0] IDLE = RUN_W'(1) << PRIO_W;

  // the virtual interface has room for a single register only
  if (VIRT && NREG != 1) begin : g_virt_check
    $error("virtual variant needs more than one active-priority register");
  end

  logic [RIDX_W-1:0]    lvl_reg;
  logic [APR_BIT_W-1:0] lvl_bit;

  prio_level_map #(
    .PRIO_W (PRIO_W),
    .MIN_BP (MIN_BP),
    .RIDX_W (RIDX_W)
  ) u_map (
    .prio    (act_prio),
    .reg_idx (lvl_reg),
    .bit_idx (lvl_bit)
  );

  // bank chosen by each command; the virtual variant has only bank 0
  logic act_bank, drop_bank;
  assign act_bank  = (NBANK == 2) && grp_en && act_grp1;
  assign drop_bank = (NBANK == 2) && drop_grp1;

  logic [FLAT_W-1:0] bank_next [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    apr_bank #(
      .NREG   (NREG),
      .RIDX_W (RIDX_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (act_valid && (act_bank == b[0])),
      .set_reg   (lvl_reg),
      .set_bit   (lvl_bit),
      .clr_en    (drop_valid && (drop_bank == b[0])),
      .bank_next (bank_next[b])
    );
  end

  logic [FLAT_W-1:0] merged;
  always_comb begin
    merged = '0;
    for (int b = 0; b < NBANK; b++) merged = merged | bank_next[b];
  end

  logic [IDX_W-1:0] low_idx;
  logic             low_found;

  lowest_set_idx #(
    .W     (FLAT_W),
    .IDX_W (IDX_W)
  ) u_find (
    .vec   (merged),
    .idx   (low_idx),
    .found (low_found)
  );

  logic [RUN_W-1:0] rebuilt_prio;
  assign rebuilt_prio = low_found ? (RUN_W'(low_idx) << (MIN_BP + 1)) : IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n)          run_prio <= IDLE;
    else if (act_valid)  run_prio <= {1'b0, act_prio};
    else if (drop_valid) run_prio <= rebuilt_prio;
  end

endmodule

// File: rtl/prio_tracker_chk.sv
module prio_tracker_chk #(
  parameter int PRIO_W = 8,
  parameter int MIN_BP = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              act_valid,
  input logic [PRIO_W-1:0] act_prio,
  input logic              drop_valid,
  input logic [PRIO_W:0]   run_prio
);

  localparam logic [PRIO_W:0] IDLE = (PRIO_W+1)'(1) << PRIO_W;
  localparam logic [PRIO_W:0] GRID = ((PRIO_W+1)'(1) << (MIN_BP + 1)) - (PRIO_W+1)'(1);

  a_r1_idle_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> run_prio == IDLE);

  a_r1_never_above_idle: assert property (@(posedge clk) disable iff (!rst_n)
    run_prio <= IDLE);

  a_r2_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_valid && drop_valid));

  a_r2_act_loads: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> run_prio == {1'b0, $past(act_prio)});

  a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_valid && !drop_valid) |=> $stable(run_prio));

  a_r3_drop_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid |=> (run_prio == IDLE) || ((run_prio & GRID) == '0));

  a_r7_idle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_valid && run_prio == IDLE) |=> run_prio == IDLE);

endmodule

bind prio_tracker prio_tracker_chk #(
  .PRIO_W (PRIO_W),
  .MIN_BP (MIN_BP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .act_valid  (act_valid),
  .act_prio   (act_prio),
  .drop_valid (drop_valid),
  .run_prio   (run_prio)
);

// File: tb/prio_tracker_bench.sv
module prio_tracker_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act_valid = 1'b0;
  logic [7:0] act_prio = '0;
  logic       act_grp1 = 1'b0;
  logic       grp_en = 1'b0;
  logic       drop_valid = 1'b0;
  logic       drop_grp1 = 1'b0;
  logic [8:0] run_p, run_v;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prio_tracker #(.VIRT(1'b0)) u_prio_tracker (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_prio(act_prio),
    .act_grp1(act_grp1), .grp_en(grp_en), .drop_valid(drop_valid),
    .drop_grp1(drop_grp1), .run_prio(run_p));

  prio_tracker #(.VIRT(1'b1)) u_prio_tracker_virt (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_prio(act_prio),
    .act_grp1(act_grp1), .grp_en(grp_en), .drop_valid(drop_valid),
    .drop_grp1(drop_grp1), .run_prio(run_v));

  // reference state: physical banks as flat level maps, virtual register
  logic [127:0] m0 = '0, m1 = '0;
  logic [31:0]  mv = '0;
  logic [8:0]   exp_p = 9'h100, exp_v = 9'h100;

  function automatic logic [8:0] prio_of128(input logic [127:0] v);
    for (int i = 0; i < 128; i++) if (v[i]) return 9'(i << 1);
    return 9'h100;
  endfunction

  function automatic logic [8:0] prio_of32(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 9'(i << 3);
    return 9'h100;
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: run_prio actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_act(input logic [7:0] p, input logic g1, input logic ge, input string tag);
    @(negedge clk);
    act_valid = 1'b1; act_prio = p; act_grp1 = g1; grp_en = ge;
    if (ge && g1) m1[p >> 1] = 1'b1;
    else          m0[p >> 1] = 1'b1;
    mv[p >> 3] = 1'b1;
    exp_p = {1'b0, p};
    exp_v = {1'b0, p};
    @(negedge clk);
    act_valid = 1'b0;
    check(tag, run_p, exp_p);
    check("R8", run_v, exp_v);
  endtask

  task automatic do_drop(input logic g1, input string tag);
    @(negedge clk);
    drop_valid = 1'b1; drop_grp1 = g1;
    if (g1) begin if (m1 != '0) m1 = m1 & (m1 - 128'd1); end
    else    begin if (m0 != '0) m0 = m0 & (m0 - 128'd1); end
    if (mv != '0) mv = mv & (mv - 32'd1);
    exp_p = prio_of128(m0 | m1);
    exp_v = prio_of32(mv);
    @(negedge clk);
    drop_valid = 1'b0;
    check(tag, run_p, exp_p);
    check("R8", run_v, exp_v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", run_p, 9'h100);
    check("R1", run_v, 9'h100);

    // R2: activates load the priority directly
    do_act(8'h40, 1'b0, 1'b1, "R2");
    do_act(8'h10, 1'b1, 1'b1, "R2");
    // R5: group-0 drop releases level 32, group-1 level 8 remains
    do_drop(1'b0, "R5");
    // R6: group-0 bank now empty
    do_drop(1'b0, "R6");
    // R7: last level released
    do_drop(1'b1, "R7");
    do_drop(1'b1, "R7");

    // R4: group-1 flag with groups disabled lands in bank 0
    do_act(8'h20, 1'b1, 1'b0, "R4");
    do_drop(1'b1, "R4");
    do_drop(1'b0, "R4");

    // R5: register boundary, levels 31, 32 and 127
    do_act(8'd62,  1'b0, 1'b1, "R5");
    do_act(8'd64,  1'b0, 1'b1, "R5");
    do_act(8'd255, 1'b0, 1'b1, "R5");
    do_drop(1'b0, "R5");
    do_drop(1'b0, "R5");
    do_drop(1'b0, "R5");

    // R9: same level twice
    do_act(8'h30, 1'b0, 1'b1, "R9");
    do_act(8'h31, 1'b0, 1'b1, "R9");
    do_drop(1'b0, "R9");

    // R3: odd priority rebuilt on the level grid
    do_act(8'h33, 1'b0, 1'b1, "R3");
    do_act(8'h80, 1'b1, 1'b1, "R3");
    do_drop(1'b1, "R3");
    do_drop(1'b0, "R7");

    // R3: random mix
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 10) < 6)
        do_act(8'($urandom), 1'($urandom), 1'($urandom % 4 != 0), "R3");
      else
        do_drop(1'($urandom), "R3");
    end
    for (int n = 0; n < 40; n++) do_drop(1'(n), "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule